// File: doc/BRIEF.md
# Transmit Jabber Guard Timer

This block watches the local transmitter and cuts it off when one transmission runs too long. A streak timer counts the consecutive clock edges on which the transmit-active flag is sampled high. When the streak reaches `JAB_LIMIT`, the block enters jabber mode. In that mode it raises two block flags, one for the transmit path and one for the loopback path, and it sets a sticky status bit. The status bit is meant to be read through a management register, because the block has no dedicated jabber pin.

While in jabber mode, a second timer counts consecutive idle edges. When that count reaches `UNJAB_LIMIT`, the block leaves jabber mode on its own. Any sampled transmit attempt restarts the idle count. When the auto-unjab-disable input is high, the automatic exit is suppressed, and only reset ends jabber mode. The status bit stays high after jabber ends and is cleared by a status-read strobe.

Top module: `jabber_guard`

## Requirements
- R1: While `rst_n` is low and after it is released, `tx_block`, `lpbk_block` and `jab_status` are 0.
- R2: When `tx_active` is sampled 1 on `JAB_LIMIT` consecutive rising edges, jabber mode is entered at the last of those edges. A run of fewer edges does not enter jabber mode, and any edge with `tx_active` at 0 restarts the count.
- R3: In jabber mode, `tx_block` and `lpbk_block` are both 1. Outside it, both are 0.
- R4: With `auto_unjab_off` at 0, jabber mode ends at the `UNJAB_LIMIT`-th consecutive edge on which `tx_active` is sampled 0.
- R5: An edge in jabber mode with `tx_active` sampled 1 restarts the idle count. The block then needs a full `UNJAB_LIMIT` idle edges again before it releases.
- R6: While `auto_unjab_off` is sampled 1, jabber mode does not end, however long transmit stays idle. Each such edge also restarts the idle count. With auto-unjab disabled, only reset ends jabber mode.
- R7: `jab_status` becomes 1 at the edge where jabber mode is entered. It stays 1 for as long as jabber mode lasts.
- R8: `jab_status` clears at an edge where `status_rd` is sampled 1 and the block was not in jabber mode before that edge. A read during jabber mode, or an edge without a read, leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Local transmitter is sending |
| auto_unjab_off | input | 1 | 1 suppresses the automatic exit from jabber mode |
| status_rd | input | 1 | Strobe from a read of the status register |
| tx_block | output | 1 | Transmit path disabled |
| lpbk_block | output | 1 | Loopback path disabled |
| jab_status | output | 1 | Sticky jabber status bit |

## Verification
The bench builds the block with `JAB_LIMIT` = 5 and `UNJAB_LIMIT` = 3. With limits this small, every burst length from 1 to `JAB_LIMIT`+2 can be swept, and every position of an interrupting transmit inside the idle wait can be tried. Status reads can be placed at every point around entry and release, and the disabled-release case can be held for many times the unjab interval. All of this takes only a few hundred cycles. An arithmetic reference in the bench predicts the three outputs after every edge.

// File: rtl/jabber_pkg.sv
package jabber_pkg;
  typedef enum logic {
    GUARD_OPEN   = 1'b0,
    GUARD_JABBER = 1'b1
  } guard_mode_e;
endpackage

// File: rtl/jab_streak_counter.sv
module jab_streak_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign done   = run && (cnt_q == LAST);
  assign cnt_en = run || (cnt_q != '0);

  always_comb begin
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_idle_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);
endmodule

// File: rtl/jab_status_bit.sv
module jab_status_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic jabbing,
  input  logic rd,
  output logic stat
);
  logic stat_q, stat_d;

  always_comb begin
    if (set)                stat_d = 1'b1;
    else if (rd && !jabbing) stat_d = 1'b0;
    else                    stat_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;

  assert_status_while_jabber_R7: assert property (@(posedge clk) disable iff (!rst_n)
    jabbing |-> stat_q);
  assert_status_clear_by_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q) |-> ($past(rd) && !$past(jabbing)));
endmodule

// File: rtl/jabber_guard.sv
module jabber_guard #(
  parameter int JAB_LIMIT   = 4096,
  parameter int UNJAB_LIMIT = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic auto_unjab_off,
  input  logic status_rd,
  output logic tx_block,
  output logic lpbk_block,
  output logic jab_status
);
  import jabber_pkg::*;

  guard_mode_e mode_q, mode_d;
  logic        in_jab;
  logic        streak_run, streak_done;
  logic        idle_run, idle_done;

  assign in_jab     = (mode_q == GUARD_JABBER);
  assign streak_run = tx_active && !in_jab;
  assign idle_run   = in_jab && !tx_active && !auto_unjab_off;

  jab_streak_counter #(.LIMIT(JAB_LIMIT)) u_tx_streak (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (streak_run),
    .done (streak_done)
  );

  jab_streak_counter #(.LIMIT(UNJAB_LIMIT)) u_idle_wait (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (idle_run),
    .done (idle_done)
  );

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      GUARD_OPEN:   if (streak_done) mode_d = GUARD_JABBER;
      GUARD_JABBER: if (idle_done)   mode_d = GUARD_OPEN;
      default:      mode_d = GUARD_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= GUARD_OPEN;
    else        mode_q <= mode_d;
  end

  jab_status_bit u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (streak_done),
    .jabbing(in_jab),
    .rd     (status_rd),
    .stat   (jab_status)
  );

  assign tx_block   = in_jab;
  assign lpbk_block = in_jab;

  assert_entry_needs_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_block) |-> $past(tx_active));
  assert_release_needs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_block) |-> (!$past(tx_active) && !$past(auto_unjab_off)));
  assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_jab && auto_unjab_off) |=> in_jab);
  assert_paths_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_block == lpbk_block) && (tx_block -> jab_status));
endmodule

// File: tb/jabber_guard_tb.sv
module jabber_guard_tb;
  localparam int JAB   = 5;
  localparam int UNJAB = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_active, auto_unjab_off, status_rd;
  logic tx_block, lpbk_block, jab_status;

  int checks = 0;
  int errors = 0;
  bit m_jab, m_stat;
  int jc, uc;

  always #10 clk = ~clk;

  jabber_guard #(.JAB_LIMIT(JAB), .UNJAB_LIMIT(UNJAB)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active),
    .auto_unjab_off(auto_unjab_off), .status_rd(status_rd),
    .tx_block(tx_block), .lpbk_block(lpbk_block), .jab_status(jab_status)
  );

  task automatic check(input string tag);
    checks++;
    if (tx_block !== m_jab || lpbk_block !== m_jab || jab_status !== m_stat) begin
      errors++;
      $display("FAIL %s: tx_block=%b lpbk_block=%b jab_status=%b expected %b %b %b",
               tag, tx_block, lpbk_block, jab_status, m_jab, m_jab, m_stat);
    end
  endtask

  // one sampled edge: drive at negedge, predict, check after the edge
  task automatic step(input bit tx, input bit rd, input bit off, input string tag);
    bit was_jab, enter;
    @(negedge clk);
    tx_active = tx; status_rd = rd; auto_unjab_off = off;
    was_jab = m_jab;
    enter = 1'b0;
    if (!was_jab) begin
      uc = 0;
      if (tx) begin
        if (jc == JAB - 1) begin enter = 1'b1; m_jab = 1'b1; jc = 0; end
        else jc++;
      end else jc = 0;
    end else begin
      jc = 0;
      if (!tx && !off) begin
        if (uc == UNJAB - 1) begin m_jab = 1'b0; uc = 0; end
        else uc++;
      end else uc = 0;
    end
    if (enter) m_stat = 1'b1;
    else if (rd && !was_jab) m_stat = 1'b0;
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tx_active = 1'b0; status_rd = 1'b0; auto_unjab_off = 1'b0;
    m_jab = 1'b0; m_stat = 1'b0; jc = 0; uc = 0;
    #1 check("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset");
  endtask

  initial begin
    rst_n = 1'b0; tx_active = 1'b0; status_rd = 1'b0; auto_unjab_off = 1'b0;
    do_reset();

    // R2 R3 R4 R7 R8: sweep burst lengths
    for (int len = 1; len <= JAB + 2; len++) begin
      for (int k = 0; k < len; k++) step(1'b1, 1'b0, 1'b0, "R2 R3 burst");
      for (int k = 0; k < UNJAB + 2; k++) step(1'b0, 1'b0, 1'b0, "R4 idle release");
      step(1'b0, 1'b1, 1'b0, "R8 read after release");
      step(1'b0, 1'b0, 1'b0, "R8 status after read");
    end

    // R5: interrupt the idle wait at every position
    for (int pos = 0; pos < UNJAB; pos++) begin
      for (int k = 0; k < JAB; k++) step(1'b1, 1'b0, 1'b0, "R2 enter");
      for (int k = 0; k < pos; k++) step(1'b0, 1'b0, 1'b0, "R5 partial idle");
      step(1'b1, 1'b0, 1'b0, "R5 restart");
      for (int k = 0; k < UNJAB + 1; k++) step(1'b0, 1'b0, 1'b0, "R5 full wait");
      step(1'b0, 1'b1, 1'b0, "R8 clear");
    end

    // R8: reads inside jabber are ignored, read at release edge ignored
    for (int k = 0; k < JAB; k++) step(1'b1, 1'b1, 1'b0, "R7 set over read");
    for (int k = 0; k < UNJAB; k++) step(1'b0, 1'b1, 1'b0, "R8 read in jabber");
    step(1'b0, 1'b0, 1'b0, "R8 no read keeps");
    step(1'b0, 1'b1, 1'b0, "R8 read clears");
    step(1'b0, 1'b1, 1'b0, "R8 read when clear");

    // R2: idle gap restarts the streak
    for (int k = 0; k < JAB - 1; k++) step(1'b1, 1'b0, 1'b0, "R2 short run");
    step(1'b0, 1'b0, 1'b0, "R2 gap");
    for (int k = 0; k < JAB - 1; k++) step(1'b1, 1'b0, 1'b0, "R2 no trip");
    step(1'b1, 1'b0, 1'b0, "R2 trip");

    // R6: auto release disabled, long idle, then reset
    for (int k = 0; k < 4 * UNJAB; k++) step(1'b0, 1'b1, 1'b1, "R6 hold");
    step(1'b0, 1'b0, 1'b0, "R6 re-enabled count restarts");
    do_reset();
    step(1'b0, 1'b0, 1'b1, "R6 R1 open after reset");

    // R6: re-enable after hold, full wait needed
    for (int k = 0; k < JAB; k++) step(1'b1, 1'b0, 1'b1, "R2 enter off");
    for (int k = 0; k < UNJAB - 1; k++) step(1'b0, 1'b0, 1'b0, "R6 partial");
    step(1'b0, 1'b0, 1'b1, "R6 off restarts");
    for (int k = 0; k < UNJAB + 1; k++) step(1'b0, 1'b0, 1'b0, "R4 release");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: expected end of run, got timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule